// File: doc/BRIEF.md
# Banked Far-Call and Far-Return Sequencer

This block carries out the two control-transfer operations of a 16-bit processor that reaches more program memory than its logical address space holds. An 8-bit page register selects which of 256 program pages shows through a 16 KB window of the 64 KB logical space. A far call switches the page and saves the way back on a byte-wide stack in data memory. A far return undoes both steps. Instruction decode and the prefetch queue live elsewhere. This block only tells the queue to reload, using a one-cycle pulse.

A call request carries a target page and a target offset. They arrive in one of two ways. In immediate mode they come in directly on input ports. In indirect mode a pointer input names a three-byte record in memory: the offset high byte, then the offset low byte, then the page byte. The call latches the old page into a holding register, switches the page register, and then stacks three bytes. It pushes the return address low byte first, then the high byte, and finally the old page byte. It then jumps. A return request pops those three bytes and loads the program counter from them. Only after that does it write the page register. While either operation runs, the block raises a busy flag. The interrupt logic uses this flag to keep the operation atomic, and any new request that arrives during this time is dropped.

Top module: `pgcall_seq`

## Requirements
- R1: After synchronous reset, page reads PAGE_RST (0), pc reads PC_RST (0), sp reads SP_RST (0x0F00), busy, done and refill are low, and mem_en stays low while no request arrives.
- R2: An immediate call loads page with tgt_page and pc with tgt_addr. It finishes with done high for exactly the cycle in which the new pc first appears.
- R3: During a call, page already holds the new page value in every cycle that writes the stack.
- R4: A call makes exactly three writes, with sp decremented before each one. It writes the return address low byte at SP0-1, the high byte at SP0-2 and the old page at SP0-3, where SP0 is sp before the call, and leaves sp = SP0-3.
- R5: The stacked return address is call_pc + 4 in immediate mode and call_pc + insn_len in indirect mode, wrapping modulo 2^16.
- R6: An indirect call reads mem at rec_ptr, then rec_ptr+1, then rec_ptr+2. It takes these as the offset high byte, the offset low byte and the page. It ignores tgt_page and tgt_addr.
- R7: A return reads sp, sp+1 and sp+2 as the page byte, the address high byte and the address low byte, and leaves sp three higher. It loads pc one cycle before page changes, and done comes with the page update. Nested calls unwind in last-in, first-out order.
- R8: busy is high from the cycle after a request is accepted until done. The busy time is 5 cycles for an immediate call, 8 for an indirect call and 5 for a return. Requests that arrive while busy have no effect.
- R9: When call_req and ret_req are both high at an idle cycle, the call runs and the return is dropped.
- R10: done and refill are high together for one cycle per completed operation and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Start a far call (sampled when idle) |
| ret_req | input | 1 | Start a far return (sampled when idle) |
| call_ind | input | 1 | 1 = indirect call through rec_ptr, 0 = immediate |
| tgt_page | input | 8 | Immediate target page |
| tgt_addr | input | 16 | Immediate target offset |
| rec_ptr | input | 16 | Address of the indirect target record |
| call_pc | input | 16 | Start address of the call instruction |
| insn_len | input | 4 | Instruction length used in indirect mode |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| page | output | 8 | Program page register |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Operation in progress; interrupts are held off |
| done | output | 1 | Operation completed (one cycle) |
| refill | output | 1 | Prefetch queue reload request (one cycle) |

## Verification
A wrong holding-register value or a stack pointer that is off by one does not show up when it happens. It shows up one operation later: a corrupted page or address byte appears on the memory write port during the push, and a misplaced frame yields a wrong pc or page at the done of the matching return. A sequencer that skips or repeats a state changes the busy length and the number of memory strobes at once, so a per-access comparison catches it within the operation itself. A page register written too early on a return becomes visible exactly one cycle before done, so the bench compares page and pc in the cycle before each return's done.

// File: rtl/pgcall_pkg.sv
package pgcall_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_HI,    // issue read of record offset high byte
    ST_RD_LO,    // issue read of offset low byte, take high byte
    ST_RD_PG,    // issue read of page byte, take low byte
    ST_SWAP,     // hold old page, install new page
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_PUSH_PG,
    ST_JUMP,
    ST_POP_PG,
    ST_POP_HI,
    ST_POP_LO,
    ST_LOAD_PC,
    ST_LOAD_PG
  } seq_state_t;

endpackage

// File: rtl/pgcall_ctl.sv
module pgcall_ctl
  import pgcall_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       call_req,
  input  logic       ret_req,
  input  logic       call_ind,
  output seq_state_t state,
  output logic       start_call,
  output logic       start_ret,
  output logic       busy,
  output logic       done
);

  seq_state_t nxt;
  logic       last_step;

  assign start_call = (state == ST_IDLE) && call_req;
  assign start_ret  = (state == ST_IDLE) && ret_req && !call_req;
  assign last_step  = (state == ST_JUMP) || (state == ST_LOAD_PG);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (start_call)     nxt = call_ind ? ST_RD_HI : ST_SWAP;
        else if (start_ret) nxt = ST_POP_PG;
      end
      ST_RD_HI:   nxt = ST_RD_LO;
      ST_RD_LO:   nxt = ST_RD_PG;
      ST_RD_PG:   nxt = ST_SWAP;
      ST_SWAP:    nxt = ST_PUSH_LO;
      ST_PUSH_LO: nxt = ST_PUSH_HI;
      ST_PUSH_HI: nxt = ST_PUSH_PG;
      ST_PUSH_PG: nxt = ST_JUMP;
      ST_JUMP:    nxt = ST_IDLE;
      ST_POP_PG:  nxt = ST_POP_HI;
      ST_POP_HI:  nxt = ST_POP_LO;
      ST_POP_LO:  nxt = ST_LOAD_PC;
      ST_LOAD_PC: nxt = ST_LOAD_PG;
      ST_LOAD_PG: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= last_step;
      if (start_call || start_ret) busy <= 1'b1;
      else if (last_step)          busy <= 1'b0;
    end
  end

  // busy flag and sequencer position must agree (interrupt hold-off)
  assert_busy_tracks_state_R8: assert property (@(posedge clk) disable iff (rst)
    busy == (state != ST_IDLE));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_call_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (call_req && ret_req && !busy) |=> (state == ST_SWAP || state == ST_RD_HI));

  assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && state != ST_JUMP && state != ST_LOAD_PG) |=> busy);

endmodule

// File: rtl/pgcall_dp.sv
module pgcall_dp
  import pgcall_pkg::*;
#(
  parameter int                LEN_W    = 4,
  parameter int                IMM_LEN  = 4,
  parameter logic [ADDR_W-1:0] SP_RST   = 16'h0F00,
  parameter logic [ADDR_W-1:0] PC_RST   = 16'h0000,
  parameter logic [BYTE_W-1:0] PAGE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state,
  input  logic              start_call,
  input  logic              call_ind,
  input  logic [BYTE_W-1:0] tgt_page,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] rec_ptr,
  input  logic [ADDR_W-1:0] call_pc,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] page,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic              ind_r;
  logic [BYTE_W-1:0] new_pg;
  logic [BYTE_W-1:0] hold_pg;
  logic [ADDR_W-1:0] dest;
  logic [ADDR_W-1:0] ptr_r;
  logic [ADDR_W-1:0] ret_a;
  logic [ADDR_W-1:0] len_sel;
  logic [ADDR_W-1:0] sp_dec;

  assign len_sel = call_ind ? ADDR_W'(insn_len) : ADDR_W'(IMM_LEN);
  assign sp_dec  = sp - ONE;

  // memory port: reads return data one cycle later
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    case (state)
      ST_RD_HI: begin mem_en = 1'b1; mem_addr = ptr_r; end
      ST_RD_LO: begin mem_en = 1'b1; mem_addr = ptr_r + ONE; end
      ST_RD_PG: begin mem_en = 1'b1; mem_addr = ptr_r + TWO; end
      ST_PUSH_LO: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_dec; mem_wdata = ret_a[BYTE_W-1:0];
      end
      ST_PUSH_HI: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_dec; mem_wdata = ret_a[ADDR_W-1:BYTE_W];
      end
      ST_PUSH_PG: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_dec; mem_wdata = hold_pg;
      end
      ST_POP_PG, ST_POP_HI, ST_POP_LO: begin mem_en = 1'b1; mem_addr = sp; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page    <= PAGE_RST;
      pc      <= PC_RST;
      sp      <= SP_RST;
      ind_r   <= 1'b0;
      new_pg  <= '0;
      hold_pg <= '0;
      dest    <= '0;
      ptr_r   <= '0;
      ret_a   <= '0;
    end else begin
      if (start_call) begin
        ind_r  <= call_ind;
        new_pg <= tgt_page;
        dest   <= tgt_addr;
        ptr_r  <= rec_ptr;
        ret_a  <= call_pc + len_sel;
      end
      case (state)
        ST_RD_LO: dest[ADDR_W-1:BYTE_W] <= mem_rdata;
        ST_RD_PG: dest[BYTE_W-1:0]      <= mem_rdata;
        ST_SWAP: begin
          hold_pg <= page;
          page    <= ind_r ? mem_rdata : new_pg;
        end
        ST_PUSH_LO, ST_PUSH_HI, ST_PUSH_PG: sp <= sp_dec;
        ST_JUMP:   pc <= dest;
        ST_POP_PG: sp <= sp + ONE;
        ST_POP_HI: begin
          sp      <= sp + ONE;
          hold_pg <= mem_rdata;
        end
        ST_POP_LO: begin
          sp                   <= sp + ONE;
          dest[ADDR_W-1:BYTE_W] <= mem_rdata;
        end
        ST_LOAD_PC: pc   <= {dest[ADDR_W-1:BYTE_W], mem_rdata};
        ST_LOAD_PG: page <= hold_pg;
        default: ;
      endcase
    end
  end

  // the page must not move while the stack is being written
  assert_page_steady_push_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(page));

  assert_sp_predec_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp == $past(sp) - ONE));

  assert_write_is_access_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  assert_page_after_pc_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD_PC) |=> $stable(page));

  assert_pc_only_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_JUMP && state != ST_LOAD_PC) |=> $stable(pc));

endmodule

// File: rtl/pgcall_seq.sv
module pgcall_seq
  import pgcall_pkg::*;
#(
  parameter int                LEN_W    = 4,
  parameter int                IMM_LEN  = 4,
  parameter logic [ADDR_W-1:0] SP_RST   = 16'h0F00,
  parameter logic [ADDR_W-1:0] PC_RST   = 16'h0000,
  parameter logic [BYTE_W-1:0] PAGE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              call_ind,
  input  logic [BYTE_W-1:0] tgt_page,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] rec_ptr,
  input  logic [ADDR_W-1:0] call_pc,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] page,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              done,
  output logic              refill
);

  seq_state_t state;
  logic       start_call;
  logic       start_ret;

  pgcall_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .call_ind   (call_ind),
    .state      (state),
    .start_call (start_call),
    .start_ret  (start_ret),
    .busy       (busy),
    .done       (done)
  );

  pgcall_dp #(
    .LEN_W    (LEN_W),
    .IMM_LEN  (IMM_LEN),
    .SP_RST   (SP_RST),
    .PC_RST   (PC_RST),
    .PAGE_RST (PAGE_RST)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .start_call (start_call),
    .call_ind   (call_ind),
    .tgt_page   (tgt_page),
    .tgt_addr   (tgt_addr),
    .rec_ptr    (rec_ptr),
    .call_pc    (call_pc),
    .insn_len   (insn_len),
    .mem_rdata  (mem_rdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .page       (page),
    .pc         (pc),
    .sp         (sp)
  );

  assign refill = done;

  assert_no_access_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !call_req && !ret_req) |=> !mem_en);

endmodule

// File: tb/tb_pgcall_seq.sv
`timescale 1ns/1ps
module tb_pgcall_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        call_req, ret_req, call_ind;
  logic [7:0]  tgt_page;
  logic [15:0] tgt_addr, rec_ptr, call_pc;
  logic [3:0]  insn_len;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  page;
  logic [15:0] pc, sp;
  logic        busy, done, refill;

  always #2.5 clk = ~clk;

  pgcall_seq dut (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req), .call_ind(call_ind),
    .tgt_page(tgt_page), .tgt_addr(tgt_addr), .rec_ptr(rec_ptr), .call_pc(call_pc),
    .insn_len(insn_len), .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .page(page), .pc(pc), .sp(sp),
    .busy(busy), .done(done), .refill(refill)
  );

  // synchronous byte memory, 4 KB image
  logic [7:0] ram [0:4095];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[11:0]];
    end
  end

  typedef struct { logic [15:0] pc; logic [7:0] pg; logic [15:0] sp; int cyc;
                   bit is_ret; logic [7:0] pre_pg; string tag; } res_t;
  typedef struct { logic [15:0] a; logic [7:0] d; logic [7:0] pg; } wr_t;
  typedef struct { logic [15:0] a; string tag; } rd_t;

  res_t res_q[$];
  wr_t  wr_q[$];
  rd_t  rd_q[$];

  logic [15:0] m_sp;
  logic [7:0]  m_pg;
  logic [15:0] fr_ret[$];
  logic [7:0]  fr_pg[$];

  int errs = 0;
  int checks = 0;
  bit mon_on = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares memory traffic and completions against the scoreboard
  int          bcnt = 0;
  logic        prev_done = 0;
  logic [15:0] prev_pc = 0;
  logic [7:0]  prev_pg = 0;
  always @(negedge clk) begin
    wr_t  w;
    rd_t  rr;
    res_t r;
    if (mon_on && !rst) begin
      if (busy) bcnt++;
      if (mem_en && mem_we) begin
        if (wr_q.size() == 0) chk(0, "R4", "unexpected write", {16'h0, mem_addr}, 0);
        else begin
          w = wr_q.pop_front();
          chk(mem_addr == w.a, "R4", "push address", {16'h0, mem_addr}, {16'h0, w.a});
          chk(mem_wdata == w.d, "R5", "pushed byte", {24'h0, mem_wdata}, {24'h0, w.d});
          chk(page == w.pg, "R3", "page during push", {24'h0, page}, {24'h0, w.pg});
        end
      end else if (mem_en) begin
        if (rd_q.size() == 0) chk(0, "R1", "unexpected read", {16'h0, mem_addr}, 0);
        else begin
          rr = rd_q.pop_front();
          chk(mem_addr == rr.a, rr.tag, "read address", {16'h0, mem_addr}, {16'h0, rr.a});
        end
      end
      if (done) begin
        chk(refill, "R10", "refill with done", {31'h0, refill}, 1);
        chk(!prev_done, "R10", "done longer than one cycle", {31'h0, prev_done}, 0);
        if (res_q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          r = res_q.pop_front();
          chk(pc == r.pc, r.tag, "pc", {16'h0, pc}, {16'h0, r.pc});
          chk(page == r.pg, r.tag, "page", {24'h0, page}, {24'h0, r.pg});
          chk(sp == r.sp, r.tag, "sp", {16'h0, sp}, {16'h0, r.sp});
          chk(bcnt == r.cyc, "R8", "busy cycles", bcnt, r.cyc);
          if (r.is_ret) begin
            chk(prev_pc == r.pc, "R7", "pc loaded before page", {16'h0, prev_pc}, {16'h0, r.pc});
            chk(prev_pg == r.pre_pg, "R7", "old page one cycle before done",
                {24'h0, prev_pg}, {24'h0, r.pre_pg});
          end
        end
        bcnt = 0;
      end
    end
    prev_done = done;
    prev_pc   = pc;
    prev_pg   = page;
  end

  task automatic wait_idle();
    int n = 0;
    while (res_q.size() != 0 && n < 100) begin
      @(posedge clk);
      n++;
    end
    repeat (2) @(posedge clk);
  endtask

  task automatic do_call(input bit ind, input logic [7:0] pg, input logic [15:0] ad,
                         input logic [15:0] ptr, input logic [15:0] cpc, input logic [3:0] len,
                         input bit both, input bit noise, input string tag);
    logic [15:0] ra;
    ra = cpc + (ind ? {12'h000, len} : 16'd4);
    if (ind) begin
      rd_q.push_back('{ptr, "R6"});
      rd_q.push_back('{ptr + 16'd1, "R6"});
      rd_q.push_back('{ptr + 16'd2, "R6"});
    end
    wr_q.push_back('{m_sp - 16'd1, ra[7:0], pg});
    wr_q.push_back('{m_sp - 16'd2, ra[15:8], pg});
    wr_q.push_back('{m_sp - 16'd3, m_pg, pg});
    fr_ret.push_back(ra);
    fr_pg.push_back(m_pg);
    m_sp = m_sp - 16'd3;
    res_q.push_back('{ad, pg, m_sp, ind ? 8 : 5, 1'b0, m_pg, tag});
    m_pg = pg;
    @(posedge clk); #1;
    call_ind = ind;
    tgt_page = ind ? 8'hEE : pg;
    tgt_addr = ind ? 16'hDEAD : ad;
    rec_ptr  = ptr;
    call_pc  = cpc;
    insn_len = len;
    call_req = 1'b1;
    ret_req  = both;
    @(posedge clk); #1;
    call_req = 1'b0;
    ret_req  = 1'b0;
    tgt_page = ~tgt_page;
    tgt_addr = ~tgt_addr;
    call_pc  = ~call_pc;
    if (noise) begin
      @(posedge clk); #1;
      call_req = 1'b1;
      ret_req  = 1'b1;
      @(posedge clk); #1;
      call_req = 1'b0;
      ret_req  = 1'b0;
    end
    wait_idle();
  endtask

  task automatic do_ret(input bit noise);
    logic [15:0] ra;
    logic [7:0]  op;
    ra = fr_ret.pop_back();
    op = fr_pg.pop_back();
    rd_q.push_back('{m_sp, "R7"});
    rd_q.push_back('{m_sp + 16'd1, "R7"});
    rd_q.push_back('{m_sp + 16'd2, "R7"});
    m_sp = m_sp + 16'd3;
    res_q.push_back('{ra, op, m_sp, 5, 1'b1, m_pg, "R7"});
    m_pg = op;
    @(posedge clk); #1;
    ret_req = 1'b1;
    @(posedge clk); #1;
    ret_req = 1'b0;
    if (noise) begin
      @(posedge clk); #1;
      call_req = 1'b1;
      @(posedge clk); #1;
      call_req = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
    ram[12'h200] = 8'h12; ram[12'h201] = 8'h34; ram[12'h202] = 8'h5A;
    ram[12'h210] = 8'hC0; ram[12'h211] = 8'h00; ram[12'h212] = 8'h3C;
    rst = 1'b1;
    call_req = 0; ret_req = 0; call_ind = 0;
    tgt_page = 0; tgt_addr = 0; rec_ptr = 0; call_pc = 0; insn_len = 0;
    m_sp = 16'h0F00;
    m_pg = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk(page == 8'h00, "R1", "reset page", {24'h0, page}, 0);
    chk(pc == 16'h0000, "R1", "reset pc", {16'h0, pc}, 0);
    chk(sp == 16'h0F00, "R1", "reset sp", {16'h0, sp}, 32'h0F00);
    chk(!busy && !done && !refill, "R1", "reset flags", {29'h0, busy, done, refill}, 0);
    chk(!mem_en, "R1", "no access at rest", {31'h0, mem_en}, 0);
    mon_on = 1;
    repeat (3) @(posedge clk);

    do_call(0, 8'h21, 16'h8100, 16'h0000, 16'h4000, 4'd0, 0, 0, "R2");  // R2 immediate
    do_call(1, 8'h5A, 16'h1234, 16'h0200, 16'h8110, 4'd3, 0, 1, "R6");  // R6 indirect + R8 noise
    do_ret(0);                                                           // R7 nested unwind
    do_ret(1);                                                           // R7 + R8 noise
    do_call(0, 8'h42, 16'h8F00, 16'h0000, 16'hFFFE, 4'd0, 0, 1, "R5");  // R5 wrap immediate
    do_call(1, 8'h3C, 16'hC000, 16'h0210, 16'hFFFF, 4'd5, 0, 0, "R5");  // R5 wrap indirect
    do_call(0, 8'h77, 16'h9000, 16'h0000, 16'h2000, 4'd0, 1, 0, "R9");  // R9 call priority
    do_ret(0);
    do_ret(0);
    do_ret(0);

    repeat (5) @(posedge clk);
    chk(res_q.size() == 0, "R8", "pending completions", res_q.size(), 0);
    chk(wr_q.size() == 0, "R4", "pending writes", wr_q.size(), 0);
    chk(rd_q.size() == 0, "R7", "pending reads", rd_q.size(), 0);
    @(negedge clk);
    chk(sp == 16'h0F00, "R7", "stack balanced", {16'h0, sp}, 32'h0F00);
    chk(page == 8'h00, "R7", "page after full unwind", {24'h0, page}, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule